// File: doc/BRIEF.md
# Stereo Codec Serial Transmitter

This block feeds a stereo audio codec from a single 50 MHz system clock. A chain of three dividers produces everything the codec needs. The system clock divided by three gives the master clock. The master clock divided by six gives the bit clock. The bit clock divided by sixty-four gives the sample-rate left/right clock. The high level of the left/right clock marks the left channel and the low level marks the right channel. All three are built from counters and enables inside the one system-clock domain, and every codec-facing line leaves the block from a flop.

Sample words arrive on a stream input. The block raises its take strobe for one system cycle per frame and captures the left and right words in that same cycle. It never waits for the valid flag, because it assumes a sample is always ready. Each word is placed at the top of a 24-bit slot, most significant bit first, and the unused low bits are filled with zeros. The word then occupies the first bit periods of a 32-bit half frame, and the remaining bit periods of that half carry zero. Serial data and the left/right clock change only as the bit clock falls, so the codec latches settled data on the rising edge.

Only the first serial lane carries audio. The remaining lanes and the static mode-strap outputs sit at zero. The power-enable output simply follows an input, so it can be held low while the clocks are checked during bring-up.

Top module: `stereo_ser_tx`

## Requirements
- R1: `mclk_o` has a period of 3 system cycles, high for 2 and low for 1.
- R2: `bclk_o` has a period of 18 system cycles (6 master-clock periods), low for 9 and then high for 9.
- R3: `lrck_o` has a period of 64 bit-clock periods (1152 system cycles). It is high (left) across the first 32 bit-clock rises of a frame and low (right) across the last 32.
- R4: `lrck_o` and `sdata_o[0]` change only in the system cycle in which `bclk_o` falls.
- R5: In the left half, bit-clock rise j (0..31) carries bit SAMP_W-1-j of the left word for j < SAMP_W. It carries 0 for every later rise, which covers both the zero padding of the 24-bit slot and the 8 unused slots.
- R6: The right half follows the same layout using the right word.
- R7: `take_o` is high for exactly one system cycle per frame, 1152 cycles apart. The words present in that cycle are sent in the frame that begins next.
- R8: `valid_i` has no effect. Words presented with `valid_i` low are taken and sent just like any others.
- R9: While `rst` (synchronous, active high) is held, `mclk_o`=1, `bclk_o`=0, `lrck_o`=1, `sdata_o[0]`=0 and `take_o`=0. The first frame after reset carries all-zero data.
- R10: `sdata_o[3:1]` and `cfg_o` stay 0, and `pwr_on_o` follows `pwr_on_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_on_i | input | 1 | Requested codec power state (1 = on) |
| valid_i | input | 1 | Stream valid flag; ignored |
| left_i | input | SAMP_W (16) | Left-channel sample word |
| right_i | input | SAMP_W (16) | Right-channel sample word |
| take_o | output | 1 | One-cycle strobe: the sample pair is consumed |
| mclk_o | output | 1 | Codec master clock |
| bclk_o | output | 1 | Serial bit clock |
| lrck_o | output | 1 | Sample clock; high = left half |
| sdata_o | output | LANES (4) | Serial data lanes; lane 0 carries audio |
| cfg_o | output | CFG_W (6) | Static codec mode straps, held at 0 |
| pwr_on_o | output | 1 | Codec power enable, follows `pwr_on_i` |

## Verification
The bench records every bit-clock rise from reset onward and rebuilds each 64-slot frame. It then compares the frames against words it captured itself on each take strobe. A design that loaded the word one slot late, padded on the wrong side, or sent anything non-zero in the unused slots would show a shifted or corrupted half frame. Two sample pairs are offered with the valid flag low, which catches a transmitter that waits for valid and would repeat old data or stall. The bench also checks that the first frame after reset is silent. It measures the duty cycles of all three clocks and confirms that data and the left/right clock never move on a rising bit-clock edge, which would hand the codec a bit that is still changing.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // True while a divider counter is in the first part of its period.
  // For odd ratios the first part is the longer one.
  function automatic logic in_first_part(input int cnt, input int ratio);
    return cnt < (ratio + 1) / 2;
  endfunction

  // Number of sample bits that fit into the codec word slot.
  function automatic int kept_bits(input int samp_w, input int word_w);
    return (samp_w < word_w) ? samp_w : word_w;
  endfunction

endpackage

// File: rtl/sertx_clkgen.sv
module sertx_clkgen #(
  parameter int MDIV       = 3,
  parameter int BDIV       = 6,
  parameter int HALF_SLOTS = 32,
  parameter int SLOT_W     = 6
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mclk_lvl,
  output logic              bclk_lvl,
  output logic              lrck_lvl,
  output logic              slot_adv,
  output logic              frame_end,
  output logic [SLOT_W-1:0] slot
);
  import sertx_pkg::*;

  localparam int FRAME_SLOTS = 2 * HALF_SLOTS;
  localparam int MW = (MDIV > 1) ? $clog2(MDIV) : 1;
  localparam int BW = (BDIV > 1) ? $clog2(BDIV) : 1;

  logic [MW-1:0] m_cnt;
  logic [BW-1:0] b_cnt;
  logic          m_last;
  logic          b_last;

  assign m_last    = (m_cnt == MW'(MDIV - 1));
  assign b_last    = (b_cnt == BW'(BDIV - 1));
  assign slot_adv  = m_last && b_last;
  assign frame_end = slot_adv && (slot == SLOT_W'(FRAME_SLOTS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      m_cnt <= '0;
      b_cnt <= '0;
      slot  <= '0;
    end else begin
      m_cnt <= m_last ? '0 : m_cnt + MW'(1);
      if (m_last) b_cnt <= b_last ? '0 : b_cnt + BW'(1);
      if (slot_adv) slot <= frame_end ? '0 : slot + SLOT_W'(1);
    end
  end

  // master clock high first, bit clock low first, left half first
  assign mclk_lvl = in_first_part(int'(m_cnt), MDIV);
  assign bclk_lvl = !in_first_part(int'(b_cnt), BDIV);
  assign lrck_lvl = (slot < SLOT_W'(HALF_SLOTS));

  // R1
  mclk_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    m_last |=> $rose(mclk_lvl));

  // R2
  bclk_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bclk_lvl) |-> $past(slot_adv));

  // R3
  left_start_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> $rose(lrck_lvl));

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int SAMP_W     = 16,
  parameter int WORD_W     = 24,
  parameter int HALF_SLOTS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [SAMP_W-1:0] left_i,
  input  logic [SAMP_W-1:0] right_i,
  output logic              bit_o
);
  import sertx_pkg::*;

  localparam int FW   = 2 * HALF_SLOTS;
  localparam int KEEP = kept_bits(SAMP_W, WORD_W);

  logic [FW-1:0] sr;

  // Place a sample at the top of a half frame; every lower slot is zero.
  function automatic logic [HALF_SLOTS-1:0] half_of(input logic [SAMP_W-1:0] s);
    logic [HALF_SLOTS-1:0] h;
    h = '0;
    h[HALF_SLOTS-1 -: KEEP] = s[SAMP_W-1 -: KEEP];
    return h;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (load) begin
      sr <= {half_of(left_i), half_of(right_i)};
    end else if (shift) begin
      sr <= {sr[FW-2:0], 1'b0};
    end
  end

  assign bit_o = sr[FW-1];

  // R5
  first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (bit_o == $past(left_i[SAMP_W-1])));

  // R5
  tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (shift && !load) |=> ($countones(sr) <= $countones($past(sr))));

endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx #(
  parameter int SAMP_W     = 16,
  parameter int WORD_W     = 24,
  parameter int HALF_SLOTS = 32,
  parameter int MDIV       = 3,
  parameter int BDIV       = 6,
  parameter int LANES      = 4,
  parameter int CFG_W      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_on_i,
  input  logic              valid_i,
  input  logic [SAMP_W-1:0] left_i,
  input  logic [SAMP_W-1:0] right_i,
  output logic              take_o,
  output logic              mclk_o,
  output logic              bclk_o,
  output logic              lrck_o,
  output logic [LANES-1:0]  sdata_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              pwr_on_o
);

  localparam int SLOT_W = $clog2(2 * HALF_SLOTS);

  logic              mclk_lvl, bclk_lvl, lrck_lvl;
  logic              slot_adv, frame_end;
  logic [SLOT_W-1:0] slot;
  logic              ser_bit;
  logic              sd_q;
  logic              unused_valid;

  assign unused_valid = valid_i;

  sertx_clkgen #(
    .MDIV(MDIV), .BDIV(BDIV), .HALF_SLOTS(HALF_SLOTS), .SLOT_W(SLOT_W)
  ) u_clk (
    .clk(clk), .rst(rst),
    .mclk_lvl(mclk_lvl), .bclk_lvl(bclk_lvl), .lrck_lvl(lrck_lvl),
    .slot_adv(slot_adv), .frame_end(frame_end), .slot(slot)
  );

  sertx_shifter #(
    .SAMP_W(SAMP_W), .WORD_W(WORD_W), .HALF_SLOTS(HALF_SLOTS)
  ) u_shift (
    .clk(clk), .rst(rst),
    .load(frame_end), .shift(slot_adv),
    .left_i(left_i), .right_i(right_i),
    .bit_o(ser_bit)
  );

  // the pair is consumed on the frame boundary edge
  assign take_o = frame_end;

  // every codec-facing line leaves through one flop; reset values match
  // the decode of the counters' reset state
  always_ff @(posedge clk) begin
    if (rst) begin
      mclk_o <= 1'b1;
      bclk_o <= 1'b0;
      lrck_o <= 1'b1;
      sd_q   <= 1'b0;
    end else begin
      mclk_o <= mclk_lvl;
      bclk_o <= bclk_lvl;
      lrck_o <= lrck_lvl;
      sd_q   <= ser_bit;
    end
  end

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i == 0) begin : g_audio
        assign sdata_o[i] = sd_q;
      end else begin : g_idle
        assign sdata_o[i] = 1'b0;
      end
    end
  endgenerate

  assign cfg_o    = '0;
  assign pwr_on_o = pwr_on_i;

  // R4
  lr_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrck_o) |-> $fell(bclk_o));

  // R4
  data_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_q) |-> $fell(bclk_o));

endmodule

// File: tb/stereo_ser_tx_test.sv
module stereo_ser_tx_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_on_i = 1'b0;
  logic        valid_i = 1'b1;
  logic [15:0] left_i;
  logic [15:0] right_i;
  logic        take_o, mclk_o, bclk_o, lrck_o, pwr_on_o;
  logic [3:0]  sdata_o;
  logic [5:0]  cfg_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  stereo_ser_tx uut (
    .clk(clk), .rst(rst), .pwr_on_i(pwr_on_i), .valid_i(valid_i),
    .left_i(left_i), .right_i(right_i), .take_o(take_o),
    .mclk_o(mclk_o), .bclk_o(bclk_o), .lrck_o(lrck_o),
    .sdata_o(sdata_o), .cfg_o(cfg_o), .pwr_on_o(pwr_on_o)
  );

  function automatic logic [15:0] pat_l(input int p);
    case (p)
      0: return 16'hFFFF;  1: return 16'h8001;  2: return 16'hA5C3;
      3: return 16'h0001;  4: return 16'h1234;  5: return 16'h0000;
      6: return 16'h5555;  default: return 16'hC0DE;
    endcase
  endfunction

  function automatic logic [15:0] pat_r(input int p);
    case (p)
      0: return 16'h0000;  1: return 16'h7FFE;  2: return 16'h3C5A;
      3: return 16'h8000;  4: return 16'hFEDC;  5: return 16'hFFFF;
      6: return 16'hAAAA;  default: return 16'h0BAD;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- stimulus driver and take recorder ----------------
  int          p = 0;
  bit          adv = 1'b0;
  int          nt = 0;
  int          cyc = 0;
  int          tk_cyc [16];
  logic [15:0] exp_l [16];
  logic [15:0] exp_r [16];
  int          take_wide = 0;
  logic        prev_take = 1'b0;

  initial begin
    left_i  = pat_l(0);
    right_i = pat_r(0);
  end

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (adv) begin
        p++;
        left_i  = pat_l(p);
        right_i = pat_r(p);
        valid_i = !(p == 2 || p == 3);   // R8: these pairs arrive with valid low
        adv = 1'b0;
      end
      if (take_o && prev_take) take_wide++;
      if (take_o && nt < 16) begin
        tk_cyc[nt] = cyc;
        exp_l[nt]  = left_i;
        exp_r[nt]  = right_i;
        nt++;
        adv = 1'b1;
      end
      prev_take = take_o;
    end
  end

  // ---------------- frame capture at bit-clock rises ----------------
  int          rise_n = 0;
  logic        cap_pb = 1'b0;
  logic [63:0] cap_d [8];
  logic [63:0] cap_l [8];

  always @(negedge clk) begin
    if (!rst) begin
      if (!cap_pb && bclk_o && rise_n < 512) begin
        cap_d[rise_n / 64][63 - (rise_n % 64)] = sdata_o[0];
        cap_l[rise_n / 64][63 - (rise_n % 64)] = lrck_o;
        rise_n++;
      end
      cap_pb = bclk_o;
    end
  end

  // ---------------- edge alignment monitor ----------------
  int   edge_bad = 0;
  int   sd_toggles = 0;
  logic e_l = 1'b1, e_d = 1'b0, e_b = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if ((lrck_o !== e_l || sdata_o[0] !== e_d) && !(e_b && !bclk_o)) edge_bad++;
      if (sdata_o[0] !== e_d) sd_toggles++;
    end
    e_l = lrck_o;
    e_d = sdata_o[0];
    e_b = bclk_o;
  end

  function automatic logic pick(input int sel);
    case (sel)
      0:       return mclk_o;
      1:       return bclk_o;
      default: return lrck_o;
    endcase
  endfunction

  // Measures one high span and the following low span of a clock output.
  task automatic span(input int sel, output int hi, output int lo);
    logic pv;
    hi = 0;
    lo = 0;
    @(negedge clk);
    pv = pick(sel);
    forever begin
      @(negedge clk);
      if (!pv && pick(sel)) break;
      pv = pick(sel);
    end
    hi = 1;
    forever begin
      @(negedge clk);
      if (pick(sel)) hi++; else break;
    end
    lo = 1;
    forever begin
      @(negedge clk);
      if (!pick(sel)) lo++; else break;
    end
  endtask

  function automatic logic [63:0] exp_frame(input int f);
    if (f == 0) return 64'h0;
    return {exp_l[f-1], 16'h0, exp_r[f-1], 16'h0};
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R9 mclk_o in reset", 64'(mclk_o), 64'd1);
    chk("R9 bclk_o in reset", 64'(bclk_o), 64'd0);
    chk("R9 lrck_o in reset", 64'(lrck_o), 64'd1);
    chk("R9 sdata_o[0] in reset", 64'(sdata_o[0]), 64'd0);
    chk("R9 take_o in reset", 64'(take_o), 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_mclk();
    int hi, lo;
    span(0, hi, lo);
    chk("R1 mclk high cycles", 64'(hi), 64'd2);
    chk("R1 mclk low cycles", 64'(lo), 64'd1);
  endtask

  task automatic t_bclk();
    int hi, lo;
    span(1, hi, lo);
    chk("R2 bclk high cycles", 64'(hi), 64'd9);
    chk("R2 bclk low cycles", 64'(lo), 64'd9);
  endtask

  task automatic t_lrck();
    int hi, lo;
    span(2, hi, lo);
    chk("R3 lrck high cycles", 64'(hi), 64'd576);
    chk("R3 lrck low cycles", 64'(lo), 64'd576);
  endtask

  task automatic t_static();
    chk("R10 idle lanes", 64'(sdata_o[3:1]), 64'd0);
    chk("R10 mode straps", 64'(cfg_o), 64'd0);
    pwr_on_i = 1'b1;
    @(negedge clk);
    chk("R10 power enable high", 64'(pwr_on_o), 64'd1);
    pwr_on_i = 1'b0;
    @(negedge clk);
    chk("R10 power enable low", 64'(pwr_on_o), 64'd0);
  endtask

  task automatic t_frames();
    logic [63:0] e;
    wait (rise_n >= 512);
    @(negedge clk);
    chk("R9 first frame silent", cap_d[0], 64'h0);
    for (int f = 1; f < 8; f++) begin
      e = exp_frame(f);
      chk("R5 left half", {32'h0, cap_d[f][63:32]}, {32'h0, e[63:32]});
      chk("R6 right half", {32'h0, cap_d[f][31:0]}, {32'h0, e[31:0]});
    end
    for (int f = 0; f < 8; f++)
      chk("R3 lrck level per slot", cap_l[f], {32'hFFFF_FFFF, 32'h0});
    chk("R8 pair taken with valid low (1)", cap_d[3], {pat_l(2), 16'h0, pat_r(2), 16'h0});
    chk("R8 pair taken with valid low (2)", cap_d[4], {pat_l(3), 16'h0, pat_r(3), 16'h0});
  endtask

  task automatic t_edges();
    chk("R4 changes only on bclk fall", 64'(edge_bad), 64'd0);
    chk("R4 data toggled during run", 64'(sd_toggles > 0), 64'd1);
  endtask

  task automatic t_take();
    chk("R7 takes seen", 64'(nt >= 7), 64'd1);
    chk("R7 strobe width one cycle", 64'(take_wide), 64'd0);
    for (int k = 1; k < 7; k++)
      chk("R7 take spacing", 64'(tk_cyc[k] - tk_cyc[k-1]), 64'd1152);
  endtask

  initial begin
    t_reset();
    t_mclk();
    t_bclk();
    t_lrck();
    t_static();
    t_frames();
    t_edges();
    t_take();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule